// File: doc/BRIEF.md
# FIR Peak-Finder Crossing Identifier

This block takes the digitised samples of one calorimeter channel, one unsigned sample per bunch crossing (one per clock), and decides which crossing held an energy deposit. A five-tap FIR filter with programmable signed coefficients shapes the pulse. A local maximum in the filter output marks the crossing of the deposit. The filter value at that maximum is scaled by a programmable right shift, clamped into an 8-bit index, and looked up in a 256-entry calibration table that is loaded through a write port.

The output is an 8-bit transverse-energy word for every crossing. It carries the calibrated value in the identified crossing and zero in every other crossing. The peak rule never accepts two adjacent crossings, so an occupied output crossing is always followed by an empty one. A downstream stage that shares one link between two channels depends on this property. A programmable noise threshold also forces small table results to zero.

Top module: `bcid_peak_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the filter history and the output register clear, so `energy_o` reads 0 during reset and stays 0 until samples taken after reset reach it.
- R2: The filter value for crossing k is F(k) = sum over i = 0..4 of c_i * x(k-i). Here x is the unsigned 10-bit sample taken at clock edge k, samples from before reset count as 0, and the signed 4-bit coefficient c_i sits in `coef_i[4i+3:4i]`. The sum is formed without overflow for every input combination.
- R3: Crossing c is identified as a peak exactly when F(c) > F(c-1) and F(c) >= F(c+1). On a flat top, only the first crossing qualifies.
- R4: The table index is F(c) arithmetically shifted right by `shift_i`. A negative result becomes index 0, and a result above 255 becomes index 255.
- R5: When `lut_we_i` is high at a clock edge, `lut_data_i` is stored at table address `lut_addr_i`, and later lookups use the new content.
- R6: For a peak crossing c whose table value passes the threshold, `energy_o` shows that table value after the fourth clock edge following the edge that took x(c), and holds it for one cycle.
- R7: For a crossing that is not a peak, `energy_o` is 0 in the corresponding cycle.
- R8: A table value below `thr_i` produces 0. A value equal to `thr_i` passes unchanged.
- R9: A cycle with nonzero `energy_o` is always followed by a cycle with `energy_o` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, one sample per edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 10 | Unsigned digitised sample for the current crossing |
| coef_i | input | 20 | Five signed 4-bit filter coefficients, tap i in bits [4i+3:4i] |
| shift_i | input | 4 | Right-shift amount applied to the filter value before indexing |
| thr_i | input | 8 | Noise threshold on the table output |
| lut_we_i | input | 1 | Table write enable |
| lut_addr_i | input | 8 | Table write address |
| lut_data_i | input | 8 | Table write data |
| energy_o | output | 8 | Calibrated energy per crossing, zero outside peaks |

## Verification
The cases that are hardest to reach from the ports depend on the shape of the filter output, not on the raw samples. Examples are a flat top where neighbouring filter values tie, a peak whose filter value is negative and must clamp to index 0, a peak above the index range, and a table value exactly equal to the threshold. The stimulus produces each of these by choosing coefficient sets deliberately. A single unit tap turns sample plateaus into filter plateaus. A negative-only tap turns falling samples into rising negative values. Maximum coefficients with a zero shift drive the index into saturation. A unit tap with a known shift and pulse height hits the threshold exactly. A behavioural model recomputes the expected energy for every crossing from the sample history.

// File: rtl/bcid_pkg.sv
package bcid_pkg;

    localparam int TAPS    = 5;
    localparam int SMP_W   = 10;
    localparam int COEF_W  = 4;
    localparam int E_W     = 8;
    localparam int SH_W    = 4;
    // product width (unsigned sample made signed, times coefficient) plus growth of the tap sum
    localparam int ACC_W   = SMP_W + 1 + COEF_W + $clog2(TAPS);
    localparam int IDX_MAX = (1 << E_W) - 1;

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic [E_W-1:0]          energy_t;

    typedef struct packed {
        logic    hit;
        energy_t idx;
    } peak_t;

    // scale a filter value and clamp it into table index range
    function automatic energy_t to_index(acc_t v, logic [SH_W-1:0] sh);
        acc_t s;
        s = v >>> sh;
        if (s < 0)
            return '0;
        else if (s > acc_t'(IDX_MAX))
            return '1;
        else
            return s[E_W-1:0];
    endfunction

endpackage

// File: rtl/bcid_fir.sv
module bcid_fir
    import bcid_pkg::*;
#(
    parameter int N_TAP  = TAPS,
    parameter int S_W    = SMP_W,
    parameter int C_W    = COEF_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [S_W-1:0]         smp_i,
    input  logic [N_TAP*C_W-1:0]   coef_i,
    output acc_t                   fir_o
);

    logic [S_W-1:0] win [N_TAP];
    acc_t           smp_ext  [N_TAP];
    acc_t           coef_ext [N_TAP];
    acc_t           prod     [N_TAP];
    acc_t           sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_TAP; i++) win[i] <= '0;
        end else begin
            win[0] <= smp_i;
            for (int i = 1; i < N_TAP; i++) win[i] <= win[i-1];
        end
    end

    for (genvar g = 0; g < N_TAP; g++) begin : g_tap
        assign smp_ext[g]  = ACC_W'($signed({1'b0, win[g]}));
        assign coef_ext[g] = ACC_W'($signed(coef_i[g*C_W +: C_W]));
        assign prod[g]     = smp_ext[g] * coef_ext[g];
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < N_TAP; i++) sum = sum + prod[i];
    end

    always_ff @(posedge clk) begin
        if (rst) fir_o <= '0;
        else     fir_o <= sum;
    end

    // R2: the window of taps moves by one crossing per edge
    AST_WINDOW_SHIFT: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> win[1] == $past(win[0])); // R2

endmodule

// File: rtl/bcid_peak.sv
module bcid_peak
    import bcid_pkg::*;
#(
    parameter int S_W = SH_W
) (
    input  logic           clk,
    input  logic           rst,
    input  acc_t           fir_i,
    input  logic [S_W-1:0] shift_i,
    output peak_t          pk_o
);

    acc_t f_mid;
    acc_t f_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_mid <= '0;
            f_old <= '0;
            pk_o  <= '0;
        end else begin
            f_mid    <= fir_i;
            f_old    <= f_mid;
            pk_o.hit <= (f_mid > f_old) && (f_mid >= fir_i);
            pk_o.idx <= to_index(f_mid, shift_i);
        end
    end

    AST_NO_DOUBLE_PEAK: assert property (@(posedge clk) disable iff (rst)
        pk_o.hit |=> !pk_o.hit); // R3

endmodule

// File: rtl/bcid_lut.sv
module bcid_lut
    import bcid_pkg::*;
#(
    parameter int A_W   = E_W,
    parameter int DEPTH = 1 << A_W
) (
    input  logic           clk,
    input  logic           rst,
    input  peak_t          pk_i,
    input  energy_t        thr_i,
    input  logic           we_i,
    input  logic [A_W-1:0] waddr_i,
    input  energy_t        wdata_i,
    output energy_t        energy_o
);

    energy_t mem [DEPTH];
    energy_t rd;

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rd = mem[pk_i.idx];

    always_ff @(posedge clk) begin
        if (rst)
            energy_o <= '0;
        else if (pk_i.hit && rd >= thr_i)
            energy_o <= rd;
        else
            energy_o <= '0;
    end

    AST_NONPEAK_ZERO: assert property (@(posedge clk) disable iff (rst)
        !pk_i.hit |=> energy_o == '0); // R7

    AST_ABOVE_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && energy_o != '0 |-> energy_o >= $past(thr_i)); // R8

    AST_ZERO_AFTER_HIT: assert property (@(posedge clk) disable iff (rst)
        energy_o != '0 |=> energy_o == '0); // R9

endmodule

// File: rtl/bcid_peak_filter.sv
module bcid_peak_filter
    import bcid_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SMP_W-1:0]         smp_i,
    input  logic [TAPS*COEF_W-1:0]   coef_i,
    input  logic [SH_W-1:0]          shift_i,
    input  logic [E_W-1:0]           thr_i,
    input  logic                     lut_we_i,
    input  logic [E_W-1:0]           lut_addr_i,
    input  logic [E_W-1:0]           lut_data_i,
    output logic [E_W-1:0]           energy_o
);

    acc_t  fir;
    peak_t pk;

    bcid_fir #(.N_TAP(TAPS), .S_W(SMP_W), .C_W(COEF_W)) u_fir (
        .clk   (clk),
        .rst   (rst),
        .smp_i (smp_i),
        .coef_i(coef_i),
        .fir_o (fir)
    );

    bcid_peak #(.S_W(SH_W)) u_peak (
        .clk    (clk),
        .rst    (rst),
        .fir_i  (fir),
        .shift_i(shift_i),
        .pk_o   (pk)
    );

    bcid_lut #(.A_W(E_W)) u_lut (
        .clk     (clk),
        .rst     (rst),
        .pk_i    (pk),
        .thr_i   (thr_i),
        .we_i    (lut_we_i),
        .waddr_i (lut_addr_i),
        .wdata_i (lut_data_i),
        .energy_o(energy_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> energy_o == '0); // R1

endmodule

// File: tb/tb_bcid_peak_filter.sv
`timescale 1ns/1ps
module tb_bcid_peak_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  smp = '0;
    logic [19:0] coef = '0;
    logic [3:0]  shift = '0;
    logic [7:0]  thr = '0;
    logic        lut_we = 1'b0;
    logic [7:0]  lut_addr = '0;
    logic [7:0]  lut_data = '0;
    logic [7:0]  energy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int xs[$];
    int cf[5];
    int sh_m, thr_m;
    int lutm[256];
    int prev_e = 0;

    always #2 clk = ~clk;

    bcid_peak_filter dut (
        .clk(clk), .rst(rst), .smp_i(smp), .coef_i(coef), .shift_i(shift),
        .thr_i(thr), .lut_we_i(lut_we), .lut_addr_i(lut_addr),
        .lut_data_i(lut_data), .energy_o(energy)
    );

    function automatic int xv(int k);
        if (k < 0 || k >= xs.size()) return 0;
        return xs[k];
    endfunction

    function automatic int fv(int k);
        int s = 0;
        for (int i = 0; i < 5; i++) s += cf[i] * xv(k - i);
        return s;
    endfunction

    task automatic report(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare the output of one crossing against the model
    task automatic check_cycle();
        int c, fc, fp, fn, s, idx, val, expv;
        bit pk;
        string tag;
        c  = xs.size() - 5;
        fc = fv(c); fp = fv(c - 1); fn = fv(c + 1);
        pk = (fc > fp) && (fc >= fn);
        s  = fc >>> sh_m;
        idx = (s < 0) ? 0 : (s > 255 ? 255 : s);
        val = lutm[idx];
        if (!pk)              begin expv = 0;   tag = "R3 R7 non-peak"; end
        else if (val < thr_m) begin expv = 0;   tag = "R8 below threshold"; end
        else                  begin expv = val; tag = "R2 R3 R4 R5 R6 peak energy"; end
        report(energy == expv[7:0], tag, energy, expv);
        if (prev_e != 0) report(energy == 0, "R9 zero after hit", energy, 0);
        prev_e = energy;
    endtask

    task automatic step(int x);
        smp = x[9:0];
        xs.push_back(x);
        @(negedge clk);
        check_cycle();
    endtask

    task automatic set_cfg(int c0, int c1, int c2, int c3, int c4, int s, int t);
        cf[0] = c0; cf[1] = c1; cf[2] = c2; cf[3] = c3; cf[4] = c4;
        for (int i = 0; i < 5; i++) coef[4*i +: 4] = cf[i][3:0];
        sh_m = s; shift = s[3:0];
        thr_m = t; thr = t[7:0];
    endtask

    task automatic load_lut(int mul, int add);
        for (int a = 0; a < 256; a++) begin
            lut_we = 1'b1; lut_addr = a[7:0];
            lutm[a] = (a * mul + add) % 256;
            lut_data = lutm[a][7:0];
            @(negedge clk);
        end
        lut_we = 1'b0;
    endtask

    task automatic do_reset(int cyc);
        rst = 1'b1; smp = '0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            report(energy == 0, "R1 reset output", energy, 0);
        end
        rst = 1'b0;
        xs.delete();
        prev_e = 0;
    endtask

    task automatic flush();
        for (int i = 0; i < 8; i++) step(0);
    endtask

    initial begin
        @(negedge clk);
        // R5: table loaded through the write port
        load_lut(3, 1);

        // smooth symmetric shape, sparse pulses
        set_cfg(1, 2, 3, 2, 1, 3, 0);
        do_reset(3);
        for (int i = 0; i < 6; i++) step(0);
        step(100); step(400); step(100);
        flush();
        for (int i = 0; i < 300; i++)
            step(($urandom % 6 == 0) ? int'($urandom % 1024) : 0);
        flush();

        // bipolar shape, dense random data, threshold active
        set_cfg(-1, 4, 6, 4, -1, 4, 20);
        do_reset(2);
        for (int i = 0; i < 300; i++) step(int'($urandom % 1024));
        flush();

        // R5: rewritten table, saturating index with shift 0 (R4)
        rst = 1'b1;
        load_lut(7, 5);
        set_cfg(7, 7, 7, 7, 7, 0, 0);
        do_reset(2);
        for (int i = 0; i < 200; i++)
            step(($urandom % 4 == 0) ? int'(512 + $urandom % 512) : 0);
        flush();

        // negative filter values: peaks clamp to index 0 (R4)
        set_cfg(-8, 0, 0, 0, 0, 1, 0);
        do_reset(2);
        step(500); step(300); step(100); step(0); step(0);
        for (int i = 0; i < 200; i++) step(int'($urandom % 1024));
        flush();

        // flat tops: first crossing of a plateau is the peak (R3)
        set_cfg(1, 0, 0, 0, 0, 0, 0);
        do_reset(2);
        step(0); step(50); step(50); step(50); step(0);
        step(30); step(60); step(60); step(20); step(20); step(0);
        flush();
        for (int i = 0; i < 200; i++) step(int'($urandom % 4) * 100);
        flush();

        // threshold boundary (R8): pulse 40 >> 2 = index 10, table value 3*... in current table 7*10+5=75
        set_cfg(1, 0, 0, 0, 0, 2, 75);
        do_reset(2);
        step(40); flush();
        set_cfg(1, 0, 0, 0, 0, 2, 76);
        do_reset(2);
        step(40); flush();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule